// File: doc/BRIEF.md
# Serial Debug Slave Port

This block is the slave end of a synchronous serial link that a debug host uses to talk to a processor's debug logic. The whole block runs on the fast system clock. The host supplies a slow serial clock and a data-in line. The block drives one data-out line. The slow serial clock is never used as a clock. It passes through synchronizer flops and acts as an oversampled enable. The block detects its rising edges internally, one system-clock cycle at a time.

Each exchange is a full-duplex packet of 17 bits, sent most significant bit first. The first bit is a control or status bit and the other 16 bits are a data word. While the host shifts a packet in, the block shifts a response out over the same edges. The core sees each received packet as a parallel word with a one-cycle strobe. At the first edge of every packet the block loads the response: a ready flag and a 16-bit word from the core. When a packet completes, a guard interval starts, and the port ignores the serial clock until that interval has elapsed. Command decoding and memory access are handled elsewhere.

Top module: `dbg_serial_port`

## Requirements
- R1: A packet is 17 bits, sent MSB first. After the 17th bit, `rx_ctl` holds the first bit received and `rx_word[15]` down to `rx_word[0]` hold bits 2 to 17 in order.
- R2: The block accepts one data-in bit for each serial-clock rising edge, and data-in is sampled together with the serial clock through the same two-flop delay.
- R3: The serial clock is sampled on system-clock edges E0, E1 and so on. If it is first sampled high at E0, `sdo_out` holds its old value after E2 and shows the new bit after E3.
- R4: A serial clock that stays high for many system cycles counts as one bit. A single low sample between two high phases is enough to separate two bits.
- R5: `rx_valid` is high for exactly one system cycle per completed packet. `rx_ctl` and `rx_word` change only in that cycle, or on reset.
- R6: The response is loaded at the first edge of a packet. If `tx_ready` is 1 then, the block sends status 0 followed by `tx_word`. If it is 0, the block sends status 1 followed by 16'hFFFF. Changing `tx_word` later in the packet has no effect on the bits sent.
- R7: After the 17th edge, serial-clock edges are ignored for 32 system cycles. An edge detected later than that starts a new packet.
- R8: Synchronous reset `rst` clears the synchronizers, the bit counter, the shift registers and the received outputs, and drives `sdo_out` low. It also discards a partial packet.
- R9: Packets are exchanged correctly at one fifth of the system clock rate and at much slower serial rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| sdi_in | input | 1 | Serial data from the host, asynchronous |
| tx_ready | input | 1 | Core has a valid response word |
| tx_word | input | 16 | Response word from the core |
| sdo_out | output | 1 | Serial data to the host, registered |
| rx_valid | output | 1 | One-cycle strobe when a packet has arrived |
| rx_ctl | output | 1 | Received control bit |
| rx_word | output | 16 | Received data word |

## Verification
The bench times the first output bit against the system clock and checks that it does not appear one cycle early or late. A design that got the pipeline depth wrong would move that bit by one cycle.

One bit has its serial clock held high for many cycles. A design that detected levels instead of edges would count extra bits and complete the packet early with a shifted word. A separate run uses only one low sample between bits, to catch a design that needs a longer low phase.

A stray bit is sent inside the guard interval, and the next packet is then started just after the interval ends. A guard that is missing, too short or too long would corrupt that packet or drop it. Two further runs check the response path and reset:
- The bench changes `tx_word` mid-packet. A design that reloads the response late would send the new value.
- The bench resets the port mid-packet. A design that keeps a stale bit count would misalign the next packet.

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int WORD_W = 16,
  parameter int GUARD  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              sdi_in,
  input  logic              tx_ready,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sdo_out,
  output logic              rx_valid,
  output logic              rx_ctl,
  output logic [WORD_W-1:0] rx_word
);
  localparam int PKT_W = WORD_W + 1;
  localparam int CNT_W = $clog2(PKT_W);
  localparam int GRD_W = $clog2(GUARD + 1);

  logic [2:0]        sclk_q;
  logic [1:0]        sdi_q;
  logic [CNT_W-1:0]  cnt;
  logic [GRD_W-1:0]  guard;
  logic [WORD_W-1:0] rx_sr;
  logic [WORD_W-1:0] tx_sr;
  logic              out_bit;

  wire rise = sclk_q[1] & ~sclk_q[2];
  wire take = rise && (guard == '0);
  wire last = (cnt == CNT_W'(PKT_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= '0;
      sdi_q    <= '0;
      cnt      <= '0;
      guard    <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      out_bit  <= 1'b0;
      sdo_out  <= 1'b0;
      rx_valid <= 1'b0;
      rx_ctl   <= 1'b0;
      rx_word  <= '0;
    end else begin
      sclk_q   <= {sclk_q[1:0], sclk_in};
      sdi_q    <= {sdi_q[0], sdi_in};
      sdo_out  <= out_bit;
      rx_valid <= 1'b0;
      if (guard != '0) guard <= guard - 1'b1;
      if (take) begin
        rx_sr <= {rx_sr[WORD_W-2:0], sdi_q[1]};
        if (cnt == '0) begin
          out_bit <= ~tx_ready;
          tx_sr   <= tx_ready ? tx_word : '1;
        end else begin
          out_bit <= tx_sr[WORD_W-1];
          tx_sr   <= {tx_sr[WORD_W-2:0], 1'b0};
        end
        if (last) begin
          cnt               <= '0;
          guard             <= GRD_W'(GUARD);
          rx_valid          <= 1'b1;
          {rx_ctl, rx_word} <= {rx_sr, sdi_q[1]};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_serial_port_chk.sv
module dbg_serial_port_chk #(
  parameter int WORD_W = 16,
  parameter int GUARD  = 32
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             rise,
  input logic [2:0]                       sclk_q,
  input logic [$clog2(WORD_W+1)-1:0]      cnt,
  input logic [$clog2(GUARD+1)-1:0]       guard,
  input logic                             sdo_out,
  input logic                             rx_valid,
  input logic                             rx_ctl,
  input logic [WORD_W-1:0]                rx_word
);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= WORD_W);

  a_r3_sdo_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rise, 2) |-> $stable(sdo_out));

  a_r4_held_once: assert property (@(posedge clk) disable iff (rst)
    (sclk_q[1] && sclk_q[2]) |=> $stable(cnt));

  a_r5_one_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(rx_word) && $stable(rx_ctl) || rx_valid);

  a_r7_guard_idle: assert property (@(posedge clk) disable iff (rst)
    (guard != '0) |=> $stable(cnt));
endmodule

bind dbg_serial_port dbg_serial_port_chk #(.WORD_W(WORD_W), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst(rst), .rise(rise), .sclk_q(sclk_q), .cnt(cnt), .guard(guard),
  .sdo_out(sdo_out), .rx_valid(rx_valid), .rx_ctl(rx_ctl), .rx_word(rx_word)
);

// File: tb/dbg_serial_port_bench.sv
module dbg_serial_port_bench;
  logic clk = 1'b0, rst = 1'b1, sclk_in = 1'b0, sdi_in = 1'b0, tx_ready = 1'b0;
  logic [15:0] tx_word = '0;
  logic sdo_out, rx_valid, rx_ctl;
  logic [15:0] rx_word;
  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;
  logic first_early, first_late;
  logic prev_v = 1'b0;
  logic [16:0] held = '0;

  always #10 clk = ~clk;

  dbg_serial_port u_dbg_serial_port (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rx_valid) pulses++;
    if (!rst) begin
      if (rx_valid && prev_v) chk(0, "R5 strobe width", 2, 1);
      if (!rx_valid && {rx_ctl, rx_word} !== held) chk(0, "R5 output hold", {rx_ctl, rx_word}, held);
    end
    held   = {rx_ctl, rx_word};
    prev_v = rx_valid;
  end

  task automatic xfer_bit(input logic b, input int hi, input int lo, output logic early, output logic late);
    @(negedge clk);
    sdi_in = b;
    sclk_in = 1'b1;
    for (int k = 1; k <= hi + lo; k++) begin
      @(negedge clk);
      if (k == hi) sclk_in = 1'b0;
      if (k == 3) early = sdo_out;
      if (k == 4) late = sdo_out;
    end
  endtask

  task automatic xfer_pkt(input logic [16:0] frame, input int hi, input int lo, input int hold_idx,
                          input int hold_hi, input bit chg_tx, output logic [16:0] got);
    logic e, l;
    for (int i = 0; i < 17; i++) begin
      xfer_bit(frame[16-i], (i == hold_idx) ? hold_hi : hi, lo, e, l);
      got[16-i] = l;
      if (i == 0) begin first_early = e; first_late = l; end
      if (i == 0 && chg_tx) tx_word = ~tx_word;
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sdo_out === 1'b0, "R8 sdo after reset", sdo_out, 0);
    chk(rx_valid === 1'b0, "R8 rx_valid after reset", rx_valid, 0);
    chk({rx_ctl, rx_word} === 17'h0, "R8 rx after reset", {rx_ctl, rx_word}, 0);
  endtask

  task automatic t_not_ready;
    logic [16:0] got;
    tx_ready = 1'b0;
    xfer_pkt(17'h0_1234, 3, 2, -1, 0, 0, got);
    chk(first_early === 1'b0, "R3 sdo not yet changed after E2", first_early, 0);
    chk(first_late === 1'b1, "R3 sdo changed after E3", first_late, 1);
    chk(got === 17'h1FFFF, "R6 not-ready response", got, 17'h1FFFF);
    chk({rx_ctl, rx_word} === 17'h0_1234, "R1 rx word", {rx_ctl, rx_word}, 17'h0_1234);
    gap(32);
  endtask

  task automatic t_basic;
    logic [16:0] got;
    int p0 = pulses;
    tx_ready = 1'b1; tx_word = 16'h3C5A;
    xfer_pkt(17'h1_A5C3, 3, 2, -1, 0, 0, got);
    chk(got === 17'h0_3C5A, "R6 ready response at fifth rate R9", got, 17'h0_3C5A);
    chk({rx_ctl, rx_word} === 17'h1_A5C3, "R1 R2 rx ctl and word", {rx_ctl, rx_word}, 17'h1_A5C3);
    chk(pulses == p0 + 1, "R5 one strobe per packet", pulses - p0, 1);
    gap(32);
  endtask

  task automatic t_load_once;
    logic [16:0] got;
    tx_ready = 1'b1; tx_word = 16'h8001;
    xfer_pkt(17'h0_0F0F, 3, 2, -1, 0, 1, got);
    chk(got === 17'h0_8001, "R6 response loaded at first edge", got, 17'h0_8001);
    gap(32);
  endtask

  task automatic t_held;
    logic [16:0] got;
    int p0 = pulses;
    xfer_pkt(17'h0_F00D, 3, 2, 5, 20, 0, got);
    chk({rx_ctl, rx_word} === 17'h0_F00D, "R4 long high counted once", {rx_ctl, rx_word}, 17'h0_F00D);
    chk(pulses == p0 + 1, "R4 packet length with long high", pulses - p0, 1);
    gap(32);
    xfer_pkt(17'h1_6B29, 4, 1, -1, 0, 0, got);
    chk({rx_ctl, rx_word} === 17'h1_6B29, "R4 single low sample separates bits", {rx_ctl, rx_word}, 17'h1_6B29);
    gap(32);
  endtask

  task automatic t_slow;
    logic [16:0] got;
    tx_ready = 1'b1; tx_word = 16'hC0DE;
    xfer_pkt(17'h0_BEEF, 40, 30, -1, 0, 0, got);
    chk({rx_ctl, rx_word} === 17'h0_BEEF, "R9 slow rx", {rx_ctl, rx_word}, 17'h0_BEEF);
    chk(got === 17'h0_C0DE, "R9 slow tx", got, 17'h0_C0DE);
    gap(32);
  endtask

  task automatic t_guard;
    logic [16:0] got;
    logic e, l;
    int p0;
    xfer_pkt(17'h1_1111, 3, 2, -1, 0, 0, got);
    p0 = pulses;
    xfer_bit(1'b1, 3, 2, e, l);
    gap(25);
    chk(pulses == p0, "R7 stray bit ignored", pulses - p0, 0);
    xfer_pkt(17'h0_2468, 3, 2, -1, 0, 0, got);
    chk({rx_ctl, rx_word} === 17'h0_2468, "R7 packet after guard", {rx_ctl, rx_word}, 17'h0_2468);
    chk(pulses == p0 + 1, "R7 strobe after guard", pulses - p0, 1);
    gap(32);
  endtask

  task automatic t_reset_mid;
    logic [16:0] got;
    logic e, l;
    for (int i = 0; i < 6; i++) xfer_bit(1'b1, 3, 2, e, l);
    rst = 1'b1;
    gap(2);
    rst = 1'b0;
    @(negedge clk);
    chk(sdo_out === 1'b0, "R8 sdo low after mid reset", sdo_out, 0);
    chk({rx_ctl, rx_word} === 17'h0, "R8 rx cleared by reset", {rx_ctl, rx_word}, 0);
    xfer_pkt(17'h1_5AA5, 3, 2, -1, 0, 0, got);
    chk({rx_ctl, rx_word} === 17'h1_5AA5, "R8 packet after mid reset", {rx_ctl, rx_word}, 17'h1_5AA5);
  endtask

  initial begin
    t_reset;
    t_not_ready;
    t_basic;
    t_load_once;
    t_held;
    t_slow;
    t_guard;
    t_reset_mid;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule